// File: doc/BRIEF.md
# Per-CPU Interval Tick Ignore Counter

This block keeps one down-counter per CPU. A shared periodic tick input drives all of them. Software loads a counter with the number of timer ticks it wants to skip. Each rising edge of the tick input decrements every counter independently. When a counter passes below zero it sets a sticky overflow flag. From then on, every tick raises a one-cycle timer pulse for that CPU.

The count field keeps decrementing after the wrap. Software can therefore read it back and work out how many ticks went by unserviced. Writing a counter reloads it and clears its overflow flag.

The timer pulse outputs feed an external per-CPU timer-interrupt flag. The tick source and that flag sit outside this block.

Top module: `tick_ign_top`

## Requirements
- R1: After reset, every counter reads count 0 with overflow clear, and every `timer_set` bit is 0.
- R2: A write (`wr_en`=1) to counter `wr_sel` stores `wr_data[CNT_W-1:0]` as its count and clears its overflow bit. Bits of `wr_data` above CNT_W-1 are ignored, and the other counters are unchanged.
- R3: `rd_data` shows counter `rd_sel` combinationally. The count is in bits [CNT_W-1:0], the overflow flag is in bit CNT_W, and every higher bit is zero.
- R4: On a tick, each counter's {overflow, count} pair is decremented as a (CNT_W+1)-bit value, and the old overflow bit is ORed back in. A count n>0 becomes n-1. A count of 0 becomes all ones with overflow set. Overflow stays set until a write.
- R5: `timer_set[i]` is high for exactly one cycle, the same cycle in which counter i shows its post-tick value, if and only if that post-tick overflow bit is 1.
- R6: Only a rising edge of `tick_in` is a tick. Holding `tick_in` high or letting it fall changes no counter and raises no pulse.
- R7: All counters react to the same tick, each from its own value.
- R8: When a write and a tick arrive in the same cycle, the written counter takes the write data with overflow clear and gives no pulse. All other counters still tick.
- R9: With the direct tick mode, a counter updates at the first clock edge at which `tick_in` is sampled high. The new value is readable from that edge on, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Shared periodic tick level |
| wr_en | input | 1 | Counter write strobe |
| wr_sel | input | SEL_W | Counter selected for write |
| wr_data | input | DATA_W | Write data; low CNT_W bits used |
| rd_sel | input | SEL_W | Counter selected for read |
| rd_data | output | DATA_W | {zeros, overflow, count} of selected counter |
| timer_set | output | NUM_CPU | Per-CPU one-cycle timer-flag set pulse |

## Verification
The bench builds the block with four counters, an 8-bit count, a 16-bit data bus and the direct tick mode. The narrow count lets a counter be driven through a whole wrap back to zero and beyond while its overflow flag stays set, well inside the cycle budget. The 16-bit bus leaves high data bits that a write must discard. With four counters, collisions between a write and a tick can be checked on one counter while its neighbours tick from different values.

// File: rtl/tick_ign_pkg.sv
package tick_ign_pkg;
   // How the tick level is brought into the clock domain before edge detection.
   typedef enum logic {
      TICK_DIRECT = 1'b0,   // level used as is, edge seen one flop later
      TICK_SYNC2  = 1'b1    // extra synchronising flop, one more cycle of delay
   } tick_mode_e;
endpackage

// File: rtl/tick_ign_edge.sv
module tick_ign_edge
   import tick_ign_pkg::*;
#(
   parameter tick_mode_e TICK_MODE = TICK_DIRECT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_in,
   output logic tick_rise
);
   logic lvl;
   logic lvl_q;

   generate
      if (TICK_MODE == TICK_SYNC2) begin : g_sync
         logic sync_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= 1'b0;
            else        sync_q <= tick_in;
         end
         assign lvl = sync_q;
      end else begin : g_direct
         assign lvl = tick_in;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign tick_rise = lvl & ~lvl_q;

   // A held level never yields two ticks in a row.
   p_single_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tick_rise |=> !tick_rise);
endmodule

// File: rtl/tick_ign_cnt.sv
module tick_ign_cnt #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_hit,
   input  logic [CNT_W-1:0] wr_val,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o,
   output logic             fire_o
);
   localparam logic [CNT_W:0] ONE      = (CNT_W+1)'(1);
   localparam logic [CNT_W:0] OVF_MASK = ONE << CNT_W;

   logic [CNT_W:0] st_q;
   logic [CNT_W:0] st_dec;
   logic [CNT_W:0] st_nxt;

   assign st_dec = st_q - ONE;
   assign st_nxt = st_dec | (st_q & OVF_MASK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= '0;
         fire_o <= 1'b0;
      end else if (wr_hit) begin
         st_q   <= {1'b0, wr_val};
         fire_o <= 1'b0;
      end else if (tick) begin
         st_q   <= st_nxt;
         fire_o <= st_nxt[CNT_W];
      end else begin
         fire_o <= 1'b0;
      end
   end

   assign cnt_o = st_q[CNT_W-1:0];
   assign ovf_o = st_q[CNT_W];

   p_write_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (!ovf_o && cnt_o == $past(wr_val)));
   p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !wr_hit) |=> ovf_o);
   p_fire_needs_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |-> ovf_o);
   p_fire_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_o && !tick) |=> !fire_o);
   p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_hit) |=> ($stable(cnt_o) && $stable(ovf_o) && !fire_o));
   p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && tick) |=> !fire_o);
endmodule

// File: rtl/tick_ign_top.sv
module tick_ign_top
   import tick_ign_pkg::*;
#(
   parameter int         NUM_CPU   = 4,
   parameter int         CNT_W     = 24,
   parameter int         DATA_W    = 32,
   parameter tick_mode_e TICK_MODE = TICK_DIRECT,
   localparam int        SEL_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_in,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic [NUM_CPU-1:0] timer_set
);
   if (NUM_CPU < 1) begin : g_bad_cpu
      $error("tick_ign_top: NUM_CPU must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("tick_ign_top: CNT_W must be at least 1");
   end
   if (DATA_W < CNT_W + 1) begin : g_bad_data
      $error("tick_ign_top: DATA_W must hold count plus overflow");
   end

   logic             tick_rise;
   logic [CNT_W-1:0] cnt_a [NUM_CPU];
   logic             ovf_a [NUM_CPU];

   tick_ign_edge #(.TICK_MODE(TICK_MODE)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_in   (tick_in),
      .tick_rise (tick_rise)
   );

   for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
      logic wr_hit;
      assign wr_hit = wr_en && (int'(wr_sel) == i);

      tick_ign_cnt #(.CNT_W(CNT_W)) u_cnt (
         .clk    (clk),
         .rst_n  (rst_n),
         .tick   (tick_rise),
         .wr_hit (wr_hit),
         .wr_val (wr_data[CNT_W-1:0]),
         .cnt_o  (cnt_a[i]),
         .ovf_o  (ovf_a[i]),
         .fire_o (timer_set[i])
      );
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_CPU; i++) begin
         if (int'(rd_sel) == i) rd_data[CNT_W:0] = {ovf_a[i], cnt_a[i]};
      end
   end

   p_rd_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data >> (CNT_W + 1)) == '0);
   p_no_fire_without_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_rise |=> (timer_set == '0));
endmodule

// File: tb/test_tick_ign_top.sv
`timescale 1ns/1ps
module test_tick_ign_top;
   import tick_ign_pkg::*;

   localparam int N  = 4;
   localparam int CW = 8;
   localparam int DW = 16;
   localparam int SW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_in = 1'b0;
   logic          wr_en = 1'b0;
   logic [SW-1:0] wr_sel = '0;
   logic [DW-1:0] wr_data = '0;
   logic [SW-1:0] rd_sel = '0;
   logic [DW-1:0] rd_data;
   logic [N-1:0]  timer_set;

   int n_run  = 0;
   int n_fail = 0;

   logic [CW-1:0] m_cnt [N];
   logic          m_ovf [N];

   always #2.5 clk = ~clk;

   tick_ign_top #(.NUM_CPU(N), .CNT_W(CW), .DATA_W(DW), .TICK_MODE(TICK_DIRECT)) i_tick_ign_top (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .timer_set(timer_set)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      for (int i = 0; i < N; i++) begin
         rd_sel = SW'(i);
         #0.1;
         chk(tag, 32'(rd_data), 32'({m_ovf[i], m_cnt[i]}));
      end
   endtask

   task automatic write_cnt(int ws, logic [DW-1:0] wd);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = SW'(ws); wr_data = wd;
      @(negedge clk);
      wr_en = 1'b0;
      m_cnt[ws] = wd[CW-1:0];
      m_ovf[ws] = 1'b0;
   endtask

   // One tick edge, optionally with a write in the same cycle.
   task automatic tick_once(string tag, bit with_wr, int ws, logic [DW-1:0] wd);
      logic [N-1:0] exp_fire;
      logic [CW:0]  st;
      @(negedge clk);
      tick_in = 1'b1;
      if (with_wr) begin
         wr_en = 1'b1; wr_sel = SW'(ws); wr_data = wd;
      end
      exp_fire = '0;
      for (int i = 0; i < N; i++) begin
         if (with_wr && i == ws) begin
            m_cnt[i] = wd[CW-1:0];
            m_ovf[i] = 1'b0;
         end else begin
            st = ({m_ovf[i], m_cnt[i]} - (CW+1)'(1)) | {m_ovf[i], {CW{1'b0}}};
            m_ovf[i] = st[CW];
            m_cnt[i] = st[CW-1:0];
            exp_fire[i] = st[CW];
         end
      end
      @(negedge clk);
      wr_en = 1'b0;
      tick_in = 1'b0;
      chk({tag, " R5 pulse"}, 32'(timer_set), 32'(exp_fire));
      check_all(tag);
      @(negedge clk);
      chk({tag, " R5 pulse ends"}, 32'(timer_set), 32'h0);
   endtask

   task automatic t_reset;
      for (int i = 0; i < N; i++) begin m_cnt[i] = '0; m_ovf[i] = 1'b0; end
      check_all("R1 reset");
      chk("R1 no pulse", 32'(timer_set), 32'h0);
   endtask

   task automatic t_write;
      write_cnt(1, 16'hF3A5);   // upper byte must be dropped
      check_all("R2 write low bits");
      rd_sel = 2'd1; #0.1;
      chk("R3 read layout", 32'(rd_data), 32'h0000_00A5);
   endtask

   task automatic t_decrement;
      write_cnt(0, 16'h0003);
      write_cnt(1, 16'h0001);
      write_cnt(2, 16'h0080);
      write_cnt(3, 16'h00FF);
      for (int k = 0; k < 4; k++) tick_once("R4 R7 decrement", 1'b0, 0, '0);
      rd_sel = 2'd0; #0.1;
      chk("R4 wrap to all ones with overflow", 32'(rd_data), 32'h0000_01FF);
   endtask

   task automatic t_sticky;
      for (int k = 0; k < 260; k++) tick_once("R4 sticky", 1'b0, 0, '0);
      rd_sel = 2'd0; #0.1;
      chk("R4 overflow kept after full wrap", 32'(rd_data[CW]), 32'h1);
   endtask

   task automatic t_level;
      @(negedge clk);
      tick_in = 1'b1;
      check_all("R9 no update before edge");
      for (int i = 0; i < N; i++) begin
         m_ovf[i] = m_ovf[i] | ({m_ovf[i], m_cnt[i]} == '0);
         m_cnt[i] = m_cnt[i] - 1'b1;
      end
      @(negedge clk);
      check_all("R9 update at first edge");
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk("R6 held level no pulse", 32'(timer_set), 32'h0);
      end
      check_all("R6 held level no change");
      tick_in = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R6 falling no pulse", 32'(timer_set), 32'h0);
      check_all("R6 falling no change");
   endtask

   task automatic t_collision;
      write_cnt(0, 16'h0010);
      write_cnt(1, 16'h0000);
      tick_once("R8 write beats tick", 1'b1, 2, 16'h0042);
      tick_once("R8 write clears overflow", 1'b1, 1, 16'h0007);
      write_cnt(3, 16'h0005);
      check_all("R2 write clears overflow");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write();
      t_decrement();
      t_sticky();
      t_level();
      t_collision();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule